// File: doc/BRIEF.md
# Three-Wire Gain Control Register

This block sits between a slow three-wire serial port and an attenuator core. A host sends an eight-bit gain word on a data line. A serial clock qualifies each bit, and an active-low frame enable brackets the word. A faster system clock samples all three lines. Each line passes through a two-flop synchronizer, and the edges of the serial clock and the frame enable are found in the system clock domain. The system clock must run at least four times faster than the serial clock.

While the frame enable is low, each rising serial clock edge pushes one data bit into a seven-bit shift register, most significant bit first. Since the register is one bit shorter than the word, the leading bit of the word falls out and is lost. The rising edge of the frame enable copies the shift register into the held gain code. That is the only moment the code the core sees can change, so a frame in progress never disturbs the core. A one-cycle pulse marks each commit. A flag reports whether the held code lies in the monotonic part of the gain range, which is codes 0 through 79.

Top module: `gain_word_port`

## Requirements
- R1: Rising serial clock edges that arrive while the frame enable is high do not change the shift register. A falling frame enable opens a frame in which edges are accepted.
- R2: Inside a frame, each rising serial clock edge shifts the data line into bit 0 of the shift register, and older bits move toward bit 6. The first bit sent therefore ends up most significant.
- R3: The shift register is 7 bits wide, so the first bit of an 8-bit word is discarded. Any word from 128 to 255 yields the same held code as that word minus 128.
- R4: A rising frame enable copies the shift register into the held code. At no other time does the held code change, including while a frame is still shifting.
- R5: The range flag is 1 exactly when the held code is 79 or less, and 0 for codes 80 to 127.
- R6: A frame with more than eight serial clock edges commits only the last seven bits received.
- R7: A frame with fewer than eight edges still commits on its closing edge. The committed value is the older register contents shifted left by the bits received.
- R8: Each commit produces a one-system-cycle update pulse in the same cycle that the new held code first appears.
- R9: After reset the held code and the shift register are 0, the range flag is 1, and no update pulse occurs.
- R10: A serial clock rising edge that is sampled in the same system cycle as the frame enable rising edge is not shifted. The commit takes the register as it was before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial clock; data is taken on its rising edge |
| serData | input | 1 | Serial data, most significant bit first |
| frameEnN | input | 1 | Active-low frame enable; its rising edge commits |
| gainCode | output | 7 | Held gain code for the attenuator core |
| codeInRange | output | 1 | 1 when gainCode is 79 or less |
| codeUpdate | output | 1 | One-cycle pulse when a new code is committed |

## Verification
The shift of a data bit and the commit of the word can fall in the same system cycle. This happens when the serial clock and the frame enable rise together. The bench provokes it by driving both lines high at the same instant after two bits of a frame. The expected held code leaves out that last bit. The bench then runs an empty frame and checks that the shift register was also left untouched by the colliding edge.

// File: rtl/gain_port_pkg.sv
package gain_port_pkg;

  localparam int CODE_W      = 7;
  localparam int MAX_MONO    = 79;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic shift;   // accept one serial bit
    logic commit;  // copy shift register to held code
  } gainStrobes_t;

endpackage

// File: rtl/gain_line_sync.sv
module gain_line_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage <= {STAGES{RST_VAL}};
    end else begin
      stage[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) begin
        stage[s] <= stage[s-1];
      end
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/gain_port_ctrl.sv
module gain_port_ctrl
  import gain_port_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         clkSync,
  input  logic         enNSync,
  output gainStrobes_t strobes
);

  logic clkPrev;
  logic enNPrev;
  logic clkRise;
  logic enRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev <= 1'b0;
      enNPrev <= 1'b1;
    end else begin
      clkPrev <= clkSync;
      enNPrev <= enNSync;
    end
  end

  assign clkRise = clkSync & ~clkPrev;
  assign enRise  = enNSync & ~enNPrev;

  // Shifting is allowed only while the frame is open in this very cycle,
  // so a clock edge that coincides with the closing edge is dropped.
  always_comb begin
    strobes        = '0;
    strobes.shift  = clkRise & ~enNSync;
    strobes.commit = enRise;
  end

  assert_shift_gated_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |-> !enNSync);

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> !strobes.shift);

  assert_commit_spaced_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> !strobes.commit);

endmodule

// File: rtl/gain_port_dpath.sv
module gain_port_dpath
  import gain_port_pkg::*;
#(
  parameter int WIDTH   = CODE_W,
  parameter int MAX_OK  = MAX_MONO
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataSync,
  input  gainStrobes_t     strobes,
  output logic [WIDTH-1:0] heldCode,
  output logic             inRange,
  output logic             updatePulse
);

  localparam logic [WIDTH-1:0] LIMIT = WIDTH'(MAX_OK);

  logic [WIDTH-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.shift) begin
      shiftReg <= {shiftReg[WIDTH-2:0], dataSync};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldCode    <= '0;
      updatePulse <= 1'b0;
    end else begin
      updatePulse <= strobes.commit;
      if (strobes.commit) begin
        heldCode <= shiftReg;
      end
    end
  end

  assign inRange = (heldCode <= LIMIT);

  assert_shift_bit_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |=> shiftReg[0] == $past(dataSync));

  assert_shift_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.shift |=> $stable(shiftReg));

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(heldCode));

  assert_pulse_with_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> updatePulse && heldCode == $past(shiftReg));

endmodule

// File: rtl/gain_word_port.sv
module gain_word_port
  import gain_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              frameEnN,
  output logic [CODE_W-1:0] gainCode,
  output logic              codeInRange,
  output logic              codeUpdate
);

  logic [2:0]   lineSync;
  gainStrobes_t strobes;

  // bit 2: frame enable (idles high), bit 1: serial clock, bit 0: data
  gain_line_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) i_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({frameEnN, serClk, serData}),
    .syncOut(lineSync)
  );

  gain_port_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .clkSync(lineSync[1]),
    .enNSync(lineSync[2]),
    .strobes(strobes)
  );

  gain_port_dpath #(
    .WIDTH (CODE_W),
    .MAX_OK(MAX_MONO)
  ) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .dataSync   (lineSync[0]),
    .strobes    (strobes),
    .heldCode   (gainCode),
    .inRange    (codeInRange),
    .updatePulse(codeUpdate)
  );

  assert_range_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    codeUpdate |-> codeInRange == (gainCode < 7'd80));

endmodule

// File: tb/test_gain_word_port.sv
module test_gain_word_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serClk = 1'b0;
  logic       serData = 1'b0;
  logic       frameEnN = 1'b1;
  logic [6:0] gainCode;
  logic       codeInRange;
  logic       codeUpdate;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  logic [6:0] pulseCode = '0;
  logic [6:0] model = '0;
  logic [6:0] held = '0;
  bit done = 0;

  gain_word_port i_gain_word_port (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .frameEnN(frameEnN), .gainCode(gainCode), .codeInRange(codeInRange),
    .codeUpdate(codeUpdate)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (codeUpdate) begin
      pulses <= pulses + 1;
      pulseCode <= gainCode;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseBit(input logic b);
    serData = b;
    waitCyc(4);
    serClk = 1'b1;
    model = {model[5:0], b};
    waitCyc(4);
    serClk = 1'b0;
  endtask

  // Sends nbits, MSB first, from bits; commits and checks the outcome.
  task automatic frame(input string req, input int nbits, input logic [15:0] bits);
    int p0;
    p0 = pulses;
    frameEnN = 1'b0;
    waitCyc(4);
    for (int i = nbits - 1; i >= 0; i--) pulseBit(bits[i]);
    chk({req, " R4 held during frame"}, gainCode, held);
    waitCyc(4);
    frameEnN = 1'b1;
    held = model;
    waitCyc(8);
    chk({req, " code"}, gainCode, held);
    chk({req, " R5 range"}, codeInRange, (held <= 79));
    chk({req, " R8 pulse count"}, pulses - p0, 1);
    chk({req, " R8 pulse aligned"}, pulseCode, held);
  endtask

  task automatic testReset();
    waitCyc(2);
    chk("R9 reset code", gainCode, 0);
    chk("R9 reset range", codeInRange, 1);
    chk("R9 no pulse", pulses, 0);
    frame("R9 empty frame after reset", 0, 16'h0);
  endtask

  task automatic testBasic();
    frame("R2 word 0x2A", 8, 16'h002A);
    frame("R2 word 0x55", 8, 16'h0055);
  endtask

  task automatic testTopBit();
    frame("R3 word 0xD0", 8, 16'h00D0);
    chk("R3 0xD0 maps to 80", gainCode, 80);
    frame("R3 word 0x50", 8, 16'h0050);
    chk("R3 0x50 maps to 80", gainCode, 80);
    frame("R3 word 0xFF", 8, 16'h00FF);
    chk("R3 0xFF maps to 127", gainCode, 127);
  endtask

  task automatic testRange();
    frame("R5 code 79", 8, 16'h004F);
    chk("R5 79 flag", codeInRange, 1);
    frame("R5 code 80", 8, 16'h0050);
    chk("R5 80 flag", codeInRange, 0);
    frame("R5 code 0", 8, 16'h0000);
    chk("R5 0 flag", codeInRange, 1);
  endtask

  task automatic testIdle();
    int p0;
    frame("R1 preload", 8, 16'h0033);
    p0 = pulses;
    for (int i = 0; i < 5; i++) begin
      serData = 1'b1;
      waitCyc(4);
      serClk = 1'b1;
      waitCyc(4);
      serClk = 1'b0;
    end
    waitCyc(6);
    chk("R1 idle edges no pulse", pulses - p0, 0);
    chk("R1 idle edges code", gainCode, 7'h33);
    frame("R1 empty frame keeps register", 0, 16'h0);
    chk("R1 register untouched", gainCode, 7'h33);
  endtask

  task automatic testLong();
    frame("R6 twelve bits", 12, 16'h0A6D);
    chk("R6 last seven", gainCode, 7'h6D);
  endtask

  task automatic testShort();
    frame("R7 preload", 8, 16'h0041);
    frame("R7 three bits", 3, 16'h0006);
    chk("R7 partial", gainCode, 7'h0E);
  endtask

  task automatic testCollide();
    int p0;
    frame("R10 preload", 8, 16'h0000);
    p0 = pulses;
    frameEnN = 1'b0;
    waitCyc(4);
    pulseBit(1'b1);
    pulseBit(1'b0);
    serData = 1'b1;
    waitCyc(4);
    serClk = 1'b1;
    frameEnN = 1'b1;
    held = model;
    waitCyc(4);
    serClk = 1'b0;
    waitCyc(6);
    chk("R10 collide code", gainCode, 7'h02);
    chk("R10 collide pulse", pulses - p0, 1);
    frame("R10 register after collide", 0, 16'h0);
    chk("R10 dropped bit", gainCode, 7'h02);
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    testReset();
    testBasic();
    testTopBit();
    testRange();
    testIdle();
    testLong();
    testShort();
    testCollide();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule